// File: doc/BRIEF.md
# Programmable Sinc3 Decimator

The block turns a one-bit oversampled stream from a sigma-delta modulator into signed 24-bit result words. Each accepted input bit counts as +1 or -1 and runs through three cascaded integrators. After every decimation period, three difference stages remove the integrator growth. The block has no multipliers and uses two's-complement arithmetic 40 bits wide throughout.

The decimation ratio is set at run time. It is four times an 11-bit notch code, so the word rate equals the modulator rate divided by that ratio. A 3-bit gain select can add a post-filter left shift. The wide value is then rounded and saturated down to 24 bits.

A resync strobe, or any change of the code, clears the filter and restarts the decimation count. This lets several converters, or a multiplexed channel, restart on a common point.

Top module: `sinc3_decim`

## Requirements
- R1: While reset is active and after its release, `valid_o` is 0 and `result_o` is 0 until the first result is produced.
- R2: An input bit of 1 contributes +1 and a bit of 0 contributes -1, so a constant 1 stream gives a positive result and a constant 0 stream gives its exact negative.
- R3: With the enable held high, `valid_o` pulses once every 4*code clock cycles, where code is the applied notch code.
- R4: A code below 10 acts as code 10 (ratio 40). A code of 3 gives pulses every 40 cycles and the same result as code 10.
- R5: Input bits are taken only in cycles where `mod_en_i` is 1. Toggling the enable every cycle doubles the pulse spacing, and holding it low produces no pulses.
- R6: Starting from a cleared filter, the third and later results for a constant input equal ±ratio³ before scaling. At code 2047 this is ±548950900672 with no internal overflow. A stream that alternates 1 and 0 on accepted samples gives exactly 0.
- R7: Gain select values 0..3 apply no digital shift. Values 4, 5, 6 and 7 shift the 40-bit filter output left by 1, 2, 3 and 4 bits.
- R8: The shifted value v becomes floor((v + 2^15) / 2^16), which is round-half-up.
- R9: Rounded values above 8388607 give 8388607 (0x7FFFFF). Values below -8388608 give -8388608 (0x800000).
- R10: A one-cycle resync strobe clears the filter and the count. No pulse follows the strobe edge, and the first new pulse appears ratio+2 cycles after it when the enable is held high.
- R11: A change of the code has the same effect as a resync. The new ratio applies from that edge, so the first pulse comes 4*newcode+2 cycles later.
- R12: `valid_o` is high for a single cycle per result, and `result_o` holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mod_bit_i | input | 1 | Modulator bit, 1 = +1, 0 = -1 |
| mod_en_i | input | 1 | Accept `mod_bit_i` this cycle |
| code_i | input | 11 | Notch code, ratio = 4*max(code,10) |
| gain_i | input | 3 | Gain select, 4..7 shift left by 1..4 |
| resync_i | input | 1 | Clear filter and restart decimation |
| result_o | output | 24 | Signed rounded, saturated result |
| valid_o | output | 1 | One-cycle pulse with each new result |

## Verification
The bench checks results at the smallest ratio, where rounding decides a result of 1 against 0. A design that truncates instead of rounding would return 0 there. At code 13 the true value is 2.15, so a design that always rounds up would give 3.

At code 2047 the integrators run close to their 40-bit limit. With a gain shift of 1, positive and negative saturation are both forced. A narrower datapath or a missing clamp would return a wrapped value.

The bench measures the latency from resync and from a code change to the first pulse. It also measures pulse spacing for codes below 10 and with an enable that toggles every cycle. A design that failed to clamp the code, counted cycles instead of accepted samples, or left stale comb state would be off in spacing or value. An alternating input must give exactly zero, which exposes an error in the input sign mapping.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int SINC_ACC_W     = 40;
  localparam int SINC_OUT_W     = 24;
  localparam int SINC_CODE_W    = 11;
  localparam int SINC_GAIN_W    = 3;
  localparam int SINC_ORDER     = 3;
  localparam int SINC_CODE_MIN  = 10;
  localparam int SINC_RATIO_SH  = 2;   // ratio = code << 2
  localparam int SINC_GAIN_BASE = 3;   // selects above this shift left
endpackage

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl #(
  parameter int CODE_W   = 11,
  parameter int RATIO_SH = 2,
  parameter int CODE_MIN = 10,
  localparam int RATIO_W = CODE_W + RATIO_SH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mod_en_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              resync_i,
  output logic              clear_o,
  output logic              sample_o,
  output logic              dump_o,
  output logic [CODE_W-1:0] code_q_o,
  output logic [RATIO_W-1:0] ratio_o
);
  localparam logic [CODE_W-1:0]  CODE_LO   = CODE_W'(CODE_MIN);
  localparam logic [RATIO_W-1:0] RATIO_RST = RATIO_W'(CODE_MIN) << RATIO_SH;

  logic [CODE_W-1:0]  code_q;
  logic [RATIO_W-1:0] ratio_q, cnt_q;
  logic               dump_q;
  logic               code_chg;
  logic [CODE_W-1:0]  code_clamp;

  assign code_chg   = (code_i != code_q);
  assign clear_o    = resync_i | code_chg;
  assign sample_o   = mod_en_i & ~clear_o;
  assign code_clamp = (code_i < CODE_LO) ? CODE_LO : code_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      ratio_q <= RATIO_RST;
    end else if (code_chg) begin
      code_q  <= code_i;
      ratio_q <= {code_clamp, {RATIO_SH{1'b0}}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      dump_q <= 1'b0;
    end else if (clear_o) begin
      cnt_q  <= '0;
      dump_q <= 1'b0;
    end else if (mod_en_i) begin
      if (cnt_q == ratio_q - RATIO_W'(1)) begin
        cnt_q  <= '0;
        dump_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + RATIO_W'(1);
        dump_q <= 1'b0;
      end
    end else begin
      dump_q <= 1'b0;
    end
  end

  assign dump_o   = dump_q;
  assign code_q_o = code_q;
  assign ratio_o  = ratio_q;
endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int ACC_W = 40,
  parameter int ORDER = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    sample_i,
  input  logic                    bit_i,
  output logic signed [ACC_W-1:0] integ_o
);
  for (genvar k = 0; k < ORDER; k++) begin : g_int
    logic signed [ACC_W-1:0] add_w;
    logic signed [ACC_W-1:0] acc_q;
    if (k == 0) begin : g_src
      assign add_w = bit_i ? ACC_W'(1) : {ACC_W{1'b1}};  // +1 / -1
    end else begin : g_src
      assign add_w = g_int[k-1].acc_q;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       acc_q <= '0;
      else if (clear_i)  acc_q <= '0;
      else if (sample_i) acc_q <= acc_q + add_w;
    end
  end

  assign integ_o = g_int[ORDER-1].acc_q;
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int ACC_W = 40,
  parameter int ORDER = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    dump_i,
  input  logic signed [ACC_W-1:0] integ_i,
  output logic signed [ACC_W-1:0] y_o,
  output logic                    vld_o
);
  for (genvar k = 0; k < ORDER; k++) begin : g_cmb
    logic signed [ACC_W-1:0] in_w, dly_q, diff_w;
    if (k == 0) begin : g_src
      assign in_w = integ_i;
    end else begin : g_src
      assign in_w = g_cmb[k-1].diff_w;
    end
    assign diff_w = in_w - dly_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      dly_q <= '0;
      else if (clear_i) dly_q <= '0;
      else if (dump_i)  dly_q <= in_w;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o   <= '0;
      vld_o <= 1'b0;
    end else if (clear_i) begin
      y_o   <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= dump_i;
      if (dump_i) y_o <= g_cmb[ORDER-1].diff_w;
    end
  end
endmodule

// File: rtl/sinc3_scale.sv
module sinc3_scale #(
  parameter int ACC_W     = 40,
  parameter int OUT_W     = 24,
  parameter int GAIN_W    = 3,
  parameter int GAIN_BASE = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic signed [ACC_W-1:0] y_i,
  input  logic                    vld_i,
  input  logic [GAIN_W-1:0]       gain_i,
  output logic [OUT_W-1:0]        result_o,
  output logic                    valid_o
);
  localparam int MAX_SH = (1 << GAIN_W) - 1 - GAIN_BASE;
  localparam int EXT_W  = ACC_W + MAX_SH + 1;
  localparam int DROP   = ACC_W - OUT_W;
  localparam logic signed [EXT_W-1:0] HALF   = EXT_W'(1) << (DROP - 1);
  localparam logic signed [EXT_W-1:0] POS_FS = (EXT_W'(1) << (OUT_W - 1)) - EXT_W'(1);
  localparam logic signed [EXT_W-1:0] NEG_FS = -POS_FS - EXT_W'(1);

  logic [GAIN_W-1:0]       sh_w;
  logic signed [EXT_W-1:0] ext_w, shl_w, rnd_w, q_w, sat_w;

  assign sh_w  = (gain_i > GAIN_W'(GAIN_BASE)) ? gain_i - GAIN_W'(GAIN_BASE) : '0;
  assign ext_w = {{(EXT_W-ACC_W){y_i[ACC_W-1]}}, y_i};
  assign shl_w = ext_w <<< sh_w;
  assign rnd_w = shl_w + HALF;
  assign q_w   = rnd_w >>> DROP;

  always_comb begin
    if (q_w > POS_FS)      sat_w = POS_FS;
    else if (q_w < NEG_FS) sat_w = NEG_FS;
    else                   sat_w = q_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= vld_i & ~clear_i;
      if (vld_i && !clear_i) result_o <= sat_w[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
  import sinc3_pkg::*;
#(
  parameter int ACC_W     = SINC_ACC_W,
  parameter int OUT_W     = SINC_OUT_W,
  parameter int CODE_W    = SINC_CODE_W,
  parameter int GAIN_W    = SINC_GAIN_W,
  parameter int ORDER     = SINC_ORDER,
  parameter int CODE_MIN  = SINC_CODE_MIN,
  parameter int RATIO_SH  = SINC_RATIO_SH,
  parameter int GAIN_BASE = SINC_GAIN_BASE,
  localparam int RATIO_W  = CODE_W + RATIO_SH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mod_bit_i,
  input  logic              mod_en_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic              resync_i,
  output logic [OUT_W-1:0]  result_o,
  output logic              valid_o
);
  logic                    clear_w, sample_w, dump_w, cvld_w;
  logic [CODE_W-1:0]       code_q;
  logic [RATIO_W-1:0]      ratio_q;
  logic signed [ACC_W-1:0] integ_w, y_w;

  sinc3_ctrl #(.CODE_W(CODE_W), .RATIO_SH(RATIO_SH), .CODE_MIN(CODE_MIN)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .mod_en_i(mod_en_i), .code_i(code_i),
    .resync_i(resync_i), .clear_o(clear_w), .sample_o(sample_w), .dump_o(dump_w),
    .code_q_o(code_q), .ratio_o(ratio_q)
  );

  sinc3_integ #(.ACC_W(ACC_W), .ORDER(ORDER)) u_integ (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_w), .sample_i(sample_w),
    .bit_i(mod_bit_i), .integ_o(integ_w)
  );

  sinc3_comb #(.ACC_W(ACC_W), .ORDER(ORDER)) u_comb (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_w), .dump_i(dump_w),
    .integ_i(integ_w), .y_o(y_w), .vld_o(cvld_w)
  );

  sinc3_scale #(.ACC_W(ACC_W), .OUT_W(OUT_W), .GAIN_W(GAIN_W), .GAIN_BASE(GAIN_BASE)) u_scale (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_w), .y_i(y_w), .vld_i(cvld_w),
    .gain_i(gain_i), .result_o(result_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk #(
  parameter int CODE_W   = 11,
  parameter int RATIO_SH = 2,
  parameter int CODE_MIN = 10,
  parameter int OUT_W    = 24,
  localparam int RATIO_W = CODE_W + RATIO_SH
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               resync_i,
  input logic [CODE_W-1:0]  code_i,
  input logic [CODE_W-1:0]  code_q,
  input logic [RATIO_W-1:0] ratio_q,
  input logic [OUT_W-1:0]   result_o,
  input logic               valid_o
);
  localparam logic [RATIO_W-1:0] RATIO_LO = RATIO_W'(CODE_MIN) << RATIO_SH;
  localparam logic [RATIO_W-1:0] RATIO_HI = RATIO_W'((1 << CODE_W) - 1) << RATIO_SH;

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R12

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o)); // R12

  AST_RESYNC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |=> !valid_o); // R10

  AST_CODE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i != code_q) |=> (!valid_o && code_q == $past(code_i))); // R11

  AST_RATIO_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_q >= RATIO_LO) && (ratio_q <= RATIO_HI) &&
    (ratio_q[RATIO_SH-1:0] == '0)); // R4
endmodule

bind sinc3_decim sinc3_decim_chk #(
  .CODE_W(CODE_W), .RATIO_SH(RATIO_SH), .CODE_MIN(CODE_MIN), .OUT_W(OUT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .resync_i(resync_i), .code_i(code_i),
  .code_q(code_q), .ratio_q(ratio_q), .result_o(result_o), .valid_o(valid_o)
);

// File: tb/sinc3_decim_bench.sv
`timescale 1ns/1ps
module sinc3_decim_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        mod_bit_i = 1'b0;
  logic        mod_en_i = 1'b0;
  logic [10:0] code_i;
  logic [2:0]  gain_i;
  logic        resync_i;
  logic [23:0] result_o;
  logic        valid_o;

  int  checks = 0;
  int  errors = 0;
  int  en_mode = 0;   // 0 always on, 1 toggle, 2 off
  bit  pat_mode = 0;  // 0 constant, 1 alternate on accepted samples
  bit  const_bit = 1;
  bit  alt_bit = 0;
  bit  done = 0;

  always #2.5 clk_i = ~clk_i;

  sinc3_decim u_sinc3_decim (
    .clk_i(clk_i), .rst_ni(rst_ni), .mod_bit_i(mod_bit_i), .mod_en_i(mod_en_i),
    .code_i(code_i), .gain_i(gain_i), .resync_i(resync_i),
    .result_o(result_o), .valid_o(valid_o)
  );

  initial begin
    forever begin
      @(negedge clk_i);
      case (en_mode)
        0:       mod_en_i = 1'b1;
        1:       mod_en_i = ~mod_en_i;
        default: mod_en_i = 1'b0;
      endcase
      if (pat_mode) begin
        if (mod_en_i) alt_bit = ~alt_bit;
        mod_bit_i = alt_bit;
      end else begin
        mod_bit_i = const_bit;
      end
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint expect_res(input bit b, input int code, input int sel);
    longint r, v;
    r = 4 * ((code < 10) ? 10 : code);
    v = r * r * r;
    if (!b) v = -v;
    if (sel > 3) v = v <<< (sel - 3);
    v = (v + 32768) >>> 16;
    if (v > 8388607)  v = 8388607;
    if (v < -8388608) v = -8388608;
    return v;
  endfunction

  function automatic longint res_s();
    return longint'($signed(result_o));
  endfunction

  task automatic wait_valid(input int lim, input string req, output int n);
    n = 0;
    do begin
      @(posedge clk_i); n++;
      @(negedge clk_i);
    end while (!valid_o && n < lim);
    if (!valid_o) chk({req, " timeout"}, n, lim + 1);
  endtask

  task automatic pulse_resync();
    @(negedge clk_i) resync_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i) resync_i = 1'b0;
  endtask

  // R1
  task automatic t_reset();
    rst_ni = 1'b0; code_i = 11'd10; gain_i = '0; resync_i = 1'b0;
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 valid in reset", valid_o, 0);
    chk("R1 result in reset", res_s(), 0);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk_i);
    chk("R1 valid after reset", valid_o, 0);
    chk("R1 result after reset", res_s(), 0);
  endtask

  task automatic t_const(input string req, input bit b, input int code, input int sel,
                         input int skip, input int n);
    int cyc;
    @(negedge clk_i);
    code_i = 11'(code); gain_i = 3'(sel); const_bit = b; pat_mode = 0; en_mode = 0;
    pulse_resync();
    for (int i = 0; i < skip + n; i++) begin
      wait_valid(4 * code + 200, req, cyc);
      if (i >= skip) chk(req, res_s(), expect_res(b, code, sel));
    end
  endtask

  task automatic t_period(input string req, input int code, input int mode, input int exp);
    int cyc;
    @(negedge clk_i);
    code_i = 11'(code); en_mode = mode; pat_mode = 0;
    wait_valid(20000, req, cyc);
    wait_valid(20000, req, cyc);
    chk(req, cyc, exp);
    en_mode = 0;
  endtask

  // R10
  task automatic t_resync(input int code);
    int cyc;
    @(negedge clk_i);
    code_i = 11'(code); en_mode = 0;
    wait_valid(20000, "R10 pre", cyc);
    repeat (5) @(negedge clk_i);
    pulse_resync();
    cyc = 1;
    while (!valid_o && cyc < 1000) begin
      @(posedge clk_i); cyc++;
      @(negedge clk_i);
    end
    chk("R10 resync latency", cyc - 1, 4 * code + 2);
  endtask

  // R11
  task automatic t_code_change(input int from_code, input int to_code);
    int cyc;
    @(negedge clk_i);
    code_i = 11'(from_code); en_mode = 0;
    wait_valid(20000, "R11 pre", cyc);
    repeat (5) @(negedge clk_i);
    code_i = 11'(to_code);
    @(posedge clk_i);
    @(negedge clk_i);
    wait_valid(1000, "R11", cyc);
    chk("R11 code change latency", cyc, 4 * to_code + 2);
  endtask

  // R6 alternating input
  task automatic t_alt(input int code);
    int cyc;
    @(negedge clk_i);
    code_i = 11'(code); gain_i = '0; pat_mode = 1; en_mode = 0;
    pulse_resync();
    for (int i = 0; i < 5; i++) begin
      wait_valid(20000, "R6 alt", cyc);
      if (i >= 3) chk("R6 alternating zero", res_s(), 0);
    end
    pat_mode = 0;
  endtask

  // R5 enable held low
  task automatic t_en_off();
    int cyc, cnt;
    @(negedge clk_i);
    code_i = 11'd10; en_mode = 0;
    wait_valid(20000, "R5 pre", cyc);
    en_mode = 2;
    repeat (4) @(negedge clk_i);
    cnt = 0;
    repeat (400) begin
      @(negedge clk_i);
      if (valid_o) cnt++;
    end
    chk("R5 no pulse while disabled", cnt, 0);
    en_mode = 0;
    wait_valid(200, "R5 resume", cyc);
    chk("R5 pulse after resume", valid_o, 1);
  endtask

  initial begin : main
    t_reset();
    t_const("R2 R8 ones round up", 1, 10, 0, 3, 2);
    t_const("R2 R8 zeros", 0, 10, 0, 3, 2);
    t_const("R7 sel3 no shift", 1, 10, 3, 3, 1);
    t_const("R7 sel5", 1, 10, 5, 3, 1);
    t_const("R7 sel7", 1, 10, 7, 3, 1);
    t_const("R2 R7 sel7 neg", 0, 10, 7, 3, 1);
    t_const("R8 round down", 1, 13, 0, 3, 1);
    t_const("R7 R8 sel4", 1, 13, 4, 3, 1);
    t_const("R4 clamp value", 1, 3, 7, 3, 1);
    t_period("R4 clamp period", 3, 0, 40);
    t_period("R3 period code25", 25, 0, 100);
    t_period("R3 period code10", 10, 0, 40);
    t_period("R5 toggled enable", 10, 1, 80);
    t_alt(20);
    t_resync(10);
    t_code_change(10, 12);
    t_en_off();
    t_const("R6 full scale code", 1, 2047, 0, 3, 2);
    t_const("R9 positive saturation", 1, 2047, 4, 3, 1);
    t_const("R9 negative saturation", 0, 2047, 4, 3, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (195000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule